// File: doc/BRIEF.md
# Ratiometric Measurement Sequencer

This block shares one voltage converter between three inputs: the battery input and two auxiliary divider inputs. It steps the converter's input selector through battery, auxiliary 0 and auxiliary 1 in a fixed, endless rotation. Each selection holds for a fixed number of time-base ticks. The block issues a one-cycle start request at the beginning of every slot. Each finished conversion is stored in the register that belongs to the input selected at that moment.

The auxiliary inputs are measured as a fraction of a divider supply, and the block switches that supply on and off. The supply enable rises a programmable number of ticks before the auxiliary 0 slot begins, so that the divider can settle. It stays high through both auxiliary slots and falls when the auxiliary 1 slot ends. A disable input keeps the supply off. Each auxiliary result has a valid flag, which is set only when that result was taken with the supply on. A sleep input freezes the rotation, suppresses start requests, turns the supply off and protects the stored results.

Top module: `ratio_meas_seq`

## Requirements
- R1: The input selector `mux_sel_o` uses the codes 0 = battery, 1 = aux 0 and 2 = aux 1, and steps 0→1→2→0 repeatedly. `conv_start_o` pulses for one cycle at the start of each slot, including the first battery slot after reset, and is deferred while asleep.
- R2: A slot lasts `SLOT_TICKS` ticks. `mux_sel_o` changes on the clock after the tick that completes the slot.
- R3: When neither disabled nor asleep, `vout_en_o` is high during the last `PRE_TICKS` ticks of the battery slot and throughout both auxiliary slots, and low at all other times.
- R4: While `vodis_i` is 1, `vout_en_o` is 0.
- R5: An auxiliary valid flag is set by a finished conversion in its slot only if `vout_en_o` was high in that cycle. Both flags clear while `vodis_i` is 1.
- R6: An auxiliary result is stored as the 12-bit signed word placed in bits 15:4, with bits 3:0 zero.
- R7: A battery result equal to positive full scale (12'h7FF) is stored as 16'h7FFF. Any other battery result is stored as in R6.
- R8: While `sleep_i` is 1, ticks are ignored, no start is issued, `vout_en_o` is 0, and a `conv_done_i` pulse changes no register or flag.
- R9: After reset, all results are 0, both flags are 0, the selector is 0 and the supply is off.
- R10: A `conv_done_i` pulse writes only the register of the input selected in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| sleep_i | input | 1 | Sleep: pause the rotation and turn the supply off |
| vodis_i | input | 1 | Divider supply disable |
| mux_sel_o | output | 2 | Converter input select |
| conv_start_o | output | 1 | Converter start request |
| conv_done_i | input | 1 | Converter result strobe |
| conv_data_i | input | DATA_W | Signed converter result |
| vout_en_o | output | 1 | Divider supply enable |
| vin_res_o | output | REG_W | Battery result register |
| ain0_res_o | output | REG_W | Auxiliary 0 result register |
| ain1_res_o | output | REG_W | Auxiliary 1 result register |
| ain0_vld_o | output | 1 | Auxiliary 0 result taken with supply on |
| ain1_vld_o | output | 1 | Auxiliary 1 result taken with supply on |

## Verification
A result register and a valid flag change on the first clock after the `conv_done_i` pulse. The selector changes, and the start request appears, one clock after the tick that completes a slot. The precharge window opens one clock after the tick that reaches it. `vout_en_o` follows `vodis_i` and `sleep_i` in the same cycle. The bench drives its inputs just after the rising edge and advances a behavioural model on that same edge. It compares every output with the model at the falling edge, so each of these latencies is checked in the cycle the result is due.

// File: rtl/ratio_seq_pkg.sv
package ratio_seq_pkg;

  typedef enum logic [1:0] {
    SEL_VIN  = 2'd0,
    SEL_AIN0 = 2'd1,
    SEL_AIN1 = 2'd2
  } sel_e;

  localparam int NUM_CH = 3;

  function automatic sel_e next_sel(sel_e cur);
    case (cur)
      SEL_VIN:  return SEL_AIN0;
      SEL_AIN0: return SEL_AIN1;
      default:  return SEL_VIN;
    endcase
  endfunction

endpackage

// File: rtl/ratio_slot_timer.sv
module ratio_slot_timer
  import ratio_seq_pkg::*;
#(
  parameter int SLOT_TICKS = 220,
  parameter int PRE_TICKS  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       sleep_i,
  output logic [1:0] sel_o,
  output logic       start_o,
  output logic       pre_o
);

  localparam int CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_TICKS - 1);
  localparam int PRE_START = SLOT_TICKS - PRE_TICKS;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  sel_e             sel_q, sel_d;
  logic             start_q, start_d;
  logic             run_q;
  logic             adv, wrap, issue;

  // next-state
  always_comb begin
    adv     = tick_i & ~sleep_i;
    wrap    = adv & (cnt_q == LAST_CNT);
    issue   = start_q & run_q & ~sleep_i;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    start_d = start_q;
    if (issue) start_d = 1'b0;
    if (adv) begin
      if (wrap) begin
        cnt_d   = '0;
        sel_d   = next_sel(sel_q);
        start_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sel_q   <= SEL_VIN;
      start_q <= 1'b1;
      run_q   <= 1'b0;
    end else begin
      if (adv) cnt_q <= cnt_d;
      if (wrap) sel_q <= sel_d;
      start_q <= start_d;
      run_q   <= 1'b1;
    end
  end

  assign sel_o   = sel_q;
  assign start_o = issue;
  assign pre_o   = (sel_q == SEL_VIN) && (int'(cnt_q) >= PRE_START);

endmodule

// File: rtl/ratio_vout_ctrl.sv
module ratio_vout_ctrl
  import ratio_seq_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       pre_i,
  input  logic       vodis_i,
  input  logic       sleep_i,
  output logic       vout_en_o
);

  logic aux_slot;

  always_comb begin
    aux_slot  = (sel_i == SEL_AIN0) || (sel_i == SEL_AIN1);
    vout_en_o = ~vodis_i & ~sleep_i & (pre_i | aux_slot);
  end

endmodule

// File: rtl/ratio_result_bank.sv
module ratio_result_bank
  import ratio_seq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int REG_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic [1:0]                    sel_i,
  input  logic                          vout_en_i,
  input  logic                          vodis_i,
  input  logic                          sleep_i,
  output logic [NUM_CH-1:0][REG_W-1:0]  res_o,
  output logic [NUM_CH-2:0]             aux_vld_o
);

  localparam int PAD_W = REG_W - DATA_W;
  localparam logic [DATA_W-1:0] POS_FS  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [REG_W-1:0]  SAT_VAL = {1'b0, {(REG_W-1){1'b1}}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic             wr;
    logic [REG_W-1:0] res_d, res_q;

    assign wr = done_i & ~sleep_i & (sel_i == 2'(ch));

    always_comb begin
      res_d = res_q;
      if (wr) begin
        if ((ch == 0) && (data_i == POS_FS)) res_d = SAT_VAL;
        else                                 res_d = {data_i, {PAD_W{1'b0}}};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  res_q <= '0;
      else if (wr) res_q <= res_d;
    end

    assign res_o[ch] = res_q;

    if (ch > 0) begin : g_vld
      logic vld_d, vld_q;

      always_comb begin
        vld_d = vld_q;
        if (wr && vout_en_i) vld_d = 1'b1;
        if (vodis_i)         vld_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      assign aux_vld_o[ch-1] = vld_q;
    end
  end

endmodule

// File: rtl/ratio_meas_seq.sv
module ratio_meas_seq
  import ratio_seq_pkg::*;
#(
  parameter int SLOT_TICKS = 220,
  parameter int PRE_TICKS  = 14,
  parameter int DATA_W     = 12,
  parameter int REG_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sleep_i,
  input  logic              vodis_i,
  output logic [1:0]        mux_sel_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              vout_en_o,
  output logic [REG_W-1:0]  vin_res_o,
  output logic [REG_W-1:0]  ain0_res_o,
  output logic [REG_W-1:0]  ain1_res_o,
  output logic              ain0_vld_o,
  output logic              ain1_vld_o
);

  logic [1:0]                   rst_sync_q;
  logic                         rst_n_s;
  logic [1:0]                   sel;
  logic                         pre;
  logic                         vout_en;
  logic [NUM_CH-1:0][REG_W-1:0] res;
  logic [NUM_CH-2:0]            vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ratio_slot_timer #(
    .SLOT_TICKS (SLOT_TICKS),
    .PRE_TICKS  (PRE_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (tick_i),
    .sleep_i (sleep_i),
    .sel_o   (sel),
    .start_o (conv_start_o),
    .pre_o   (pre)
  );

  ratio_vout_ctrl u_vout (
    .sel_i     (sel),
    .pre_i     (pre),
    .vodis_i   (vodis_i),
    .sleep_i   (sleep_i),
    .vout_en_o (vout_en)
  );

  ratio_result_bank #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .done_i    (conv_done_i),
    .data_i    (conv_data_i),
    .sel_i     (sel),
    .vout_en_i (vout_en),
    .vodis_i   (vodis_i),
    .sleep_i   (sleep_i),
    .res_o     (res),
    .aux_vld_o (vld)
  );

  assign mux_sel_o  = sel;
  assign vout_en_o  = vout_en;
  assign vin_res_o  = res[0];
  assign ain0_res_o = res[1];
  assign ain1_res_o = res[2];
  assign ain0_vld_o = vld[0];
  assign ain1_vld_o = vld[1];

endmodule

// File: rtl/ratio_meas_seq_chk.sv
module ratio_meas_seq_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic             vodis_i,
  input logic [1:0]       mux_sel_o,
  input logic             conv_start_o,
  input logic             conv_done_i,
  input logic             vout_en_o,
  input logic [REG_W-1:0] vin_res_o,
  input logic [REG_W-1:0] ain0_res_o,
  input logic [REG_W-1:0] ain1_res_o,
  input logic             ain0_vld_o,
  input logic             ain1_vld_o
);

  // R1
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel_o != $past(mux_sel_o)) |->
      (mux_sel_o == (($past(mux_sel_o) == 2'd2) ? 2'd0 : $past(mux_sel_o) + 2'd1)));

  // R1
  start_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel_o != $past(mux_sel_o)) |-> (conv_start_o || sleep_i));

  // R3
  vout_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel_o != 2'd0 && !vodis_i && !sleep_i) |-> vout_en_o);

  // R4
  vodis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vodis_i |-> !vout_en_o);

  // R5
  ain0_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ain0_vld_o) |-> $past(vout_en_o && conv_done_i && mux_sel_o == 2'd1));

  // R5
  ain1_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ain1_vld_o) |-> $past(vout_en_o && conv_done_i && mux_sel_o == 2'd2));

  // R5
  vld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vodis_i |=> (!ain0_vld_o && !ain1_vld_o));

  // R6
  aux_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ain0_res_o[3:0] == 4'd0) && (ain1_res_o[3:0] == 4'd0));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (!vout_en_o && !conv_start_o));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(vin_res_o) && $stable(ain0_res_o) && $stable(ain1_res_o)));

endmodule

bind ratio_meas_seq ratio_meas_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_i      (sleep_i),
  .vodis_i      (vodis_i),
  .mux_sel_o    (mux_sel_o),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .vout_en_o    (vout_en_o),
  .vin_res_o    (vin_res_o),
  .ain0_res_o   (ain0_res_o),
  .ain1_res_o   (ain1_res_o),
  .ain0_vld_o   (ain0_vld_o),
  .ain1_vld_o   (ain1_vld_o)
);

// File: tb/ratio_meas_seq_bench.sv
`timescale 1ns/1ps
module ratio_meas_seq_bench;

  localparam int S  = 8;
  localparam int P  = 3;
  localparam int DW = 12;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          sleep_i = 1'b0;
  logic          vodis_i = 1'b0;
  logic [1:0]    mux_sel_o;
  logic          conv_start_o;
  logic          conv_done_i;
  logic [DW-1:0] conv_data_i = '0;
  logic          vout_en_o;
  logic [RW-1:0] vin_res_o, ain0_res_o, ain1_res_o;
  logic          ain0_vld_o, ain1_vld_o;

  logic cvt_done = 1'b0;
  logic inj_done = 1'b0;
  assign conv_done_i = cvt_done | inj_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ratio_meas_seq #(.SLOT_TICKS(S), .PRE_TICKS(P), .DATA_W(DW), .REG_W(RW)) u_ratio_meas_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_i), .vodis_i(vodis_i),
    .mux_sel_o(mux_sel_o), .conv_start_o(conv_start_o), .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i), .vout_en_o(vout_en_o), .vin_res_o(vin_res_o),
    .ain0_res_o(ain0_res_o), .ain1_res_o(ain1_res_o),
    .ain0_vld_o(ain0_vld_o), .ain1_vld_o(ain1_vld_o)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // behavioural reference model
  int  m_sync = 0;
  int  m_slot, m_cnt;
  bit  m_start, m_run, m_v0, m_v1;
  int  m_res [3];

  function automatic bit m_vout();
    return !vodis_i && !sleep_i && (m_slot != 0 || m_cnt >= S - P);
  endfunction

  function automatic int fmt(int ch, logic [DW-1:0] d);
    if (ch == 0 && d == 12'h7FF) return 32'h7FFF;
    return int'({d, 4'h0});
  endfunction

  task automatic m_reset();
    m_slot = 0; m_cnt = 0; m_start = 1; m_run = 0; m_v0 = 0; m_v1 = 0;
    for (int i = 0; i < 3; i++) m_res[i] = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0;
      m_reset();
    end else if (m_sync < 2) begin
      m_sync++;
      m_reset();
    end else begin
      bit v, issued;
      v = m_vout();
      issued = m_start && m_run && !sleep_i;
      if (conv_done_i && !sleep_i) begin
        m_res[m_slot] = fmt(m_slot, conv_data_i);
        if (m_slot == 1 && v) m_v0 = 1;
        if (m_slot == 2 && v) m_v1 = 1;
      end
      if (vodis_i) begin m_v0 = 0; m_v1 = 0; end
      if (issued) m_start = 0;
      if (tick_i && !sleep_i) begin
        if (m_cnt == S - 1) begin
          m_cnt = 0; m_slot = (m_slot + 1) % 3; m_start = 1;
        end else m_cnt++;
      end
      m_run = 1;
    end
  end

  // comparison every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && m_sync >= 2) begin
      check("R1 R2 mux_sel", int'(mux_sel_o), m_slot);
      check("R1 conv_start", int'(conv_start_o), int'(m_start && m_run && !sleep_i));
      if (sleep_i)      check("R8 vout_en", int'(vout_en_o), 0);
      else if (vodis_i) check("R4 vout_en", int'(vout_en_o), 0);
      else              check("R3 vout_en", int'(vout_en_o), int'(m_vout()));
      check("R7 R10 vin_res", int'(vin_res_o), m_res[0]);
      check("R6 R10 ain0_res", int'(ain0_res_o), m_res[1]);
      check("R6 R10 ain1_res", int'(ain1_res_o), m_res[2]);
      check("R5 ain0_vld", int'(ain0_vld_o), int'(m_v0));
      check("R5 ain1_vld", int'(ain1_vld_o), int'(m_v1));
    end
  end

  // time base: one tick every other cycle
  int tcnt = 0;
  always @(posedge clk) begin
    #1;
    tcnt++;
    tick_i = (tcnt % 2 == 0);
  end

  // converter emulation: result four cycles after a start
  function automatic logic [DW-1:0] pattern(int k);
    case (k % 6)
      0: return 12'h7FF;
      1: return 12'h123;
      2: return 12'h800;
      3: return 12'hFFF;
      4: return 12'h7FE;
      default: return 12'h400;
    endcase
  endfunction

  int cd = 0;
  int pidx = 0;
  always @(posedge clk) begin
    #1;
    cvt_done = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        cvt_done = 1'b1;
        conv_data_i = pattern(pidx);
        pidx++;
      end
    end
    if (conv_start_o) cd = 4;
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R9: reset state, observed while reset is held
    @(negedge clk);
    check("R9 vin_res", int'(vin_res_o), 0);
    check("R9 ain0_res", int'(ain0_res_o), 0);
    check("R9 ain1_res", int'(ain1_res_o), 0);
    check("R9 valids", int'({ain0_vld_o, ain1_vld_o}), 0);
    check("R9 mux_sel", int'(mux_sel_o), 0);
    check("R9 vout_en", int'(vout_en_o), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cycles(200);           // normal rotation, R1 R2 R3 R6 R7
    vodis_i = 1'b1;        // R4, R5 clearing
    cycles(100);
    vodis_i = 1'b0;
    cycles(120);
    sleep_i = 1'b1;        // R8
    cycles(10);
    conv_data_i = 12'h555;
    inj_done = 1'b1;
    cycles(1);
    inj_done = 1'b0;
    cycles(30);
    sleep_i = 1'b0;
    cycles(150);
    vodis_i = 1'b1;        // disable in the middle of aux slots
    cycles(20);
    vodis_i = 1'b0;
    cycles(100);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule